// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block keeps a set of sticky interrupt flags raised by single-cycle event pulses from a transfer engine, a matching set of enable bits, and a soft-reset control bit. It folds the flags and enables into one interrupt line. Software reaches the block through a simple single-cycle register port. Every register can be read or written at its base address. It can also be changed one bit at a time through a set alias at base + 0x4 and a clear alias at base + 0x8, so no read-modify-write is needed.

The interrupt register holds eight status flags in bits 7:0. Their meanings, by bit, are: 0 slave event, 1 slave stop seen, 2 arbitration lost, 3 transfer ended early, 4 oversize transfer, 5 address not acknowledged, 6 engine finished, 7 bus idle. The enable for flag i sits at bit i + 8. The control register carries the soft-reset bit in bit 31. The default map places the control register at 0x00 and the interrupt register at 0x10. A handler acknowledges events by writing the status value it read back to the clear alias.

Top module: `irq_status_regs`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `soft_rst_o` is low.
- R2: A high level on `evt_i[i]` at a clock edge sets status bit i. The bit then stays set until software clears it or a soft reset occurs.
- R3: A write to the clear alias (base + 0x8) clears exactly the bits written as one. All other bits of that register keep their value.
- R4: A write to the set alias (base + 0x4) sets exactly the bits written as one. All other bits of that register keep their value.
- R5: A write to the base address of the interrupt register loads status from bits 7:0 and enables from bits 15:8.
- R6: The enable for status bit i is bit i + 8. `irq_o` is high exactly when some status bit and its own enable are both set.
- R7: If an event and a software clear or overwrite reach the same status bit in the same cycle, the bit ends up set.
- R8: A read from the set alias or the clear alias returns the same value as a read from the base address of the same register.
- R9: Setting control bit 31 takes effect at the same edge and clears all status and enable bits. While bit 31 stays set, status and enables remain zero, events and interrupt-register writes are ignored, and `irq_o` is low. `soft_rst_o` shows bit 31, and clearing bit 31 releases the block.
- R10: Bits 31:16 of the interrupt register and bits 30:0 of the control register read zero and ignore writes. Offsets 0x1, 0x2, 0x3 and 0xC inside a register, and addresses outside both registers, read zero and change nothing.
- R11: Writing the read-back low byte to the clear alias acknowledges exactly those events and leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| evt_i | input | 8 | Event pulses from the transfer engine, one per status bit |
| irq_o | output | 1 | Interrupt request |
| soft_rst_o | output | 1 | Current state of the soft-reset bit |

## Verification
The bench drives event pulses in the same cycle as clear-alias and base writes to the same bit. A design that gives software priority there loses the event and reads back a zero flag. It sweeps each status bit against its own enable and against every other enable. A wrong enable offset, or an AND across the wrong bits, shows up as a wrong `irq_o` level. It writes all-ones data through the set alias, through unmapped offsets and into reserved bit fields. It also drives events and writes while the soft-reset bit is held. A decoder that ignores the low address bits, or a soft reset that takes effect one cycle late, leaves bits it should not and is caught on read-back.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SRST_BIT = 31;

  // Alias selected by address bits 3:2 of a register access.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;

  function automatic logic apply_op(alias_op_e op, logic cur, logic w);
    logic res;
    case (op)
      OP_WRITE: res = w;
      OP_SET:   res = cur | w;
      OP_CLEAR: res = cur & ~w;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/irqs_decode.sv
module irqs_decode
  import irqs_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]     CTRL_BASE = 'h00,
  parameter logic [ADDR_W-1:0]     IRQ_BASE  = 'h10
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output alias_op_e         op,
  output logic              ctrl_hit,
  output logic              irq_hit,
  output logic              ctrl_wr,
  output logic              irq_wr
);

  localparam int unsigned BLK_LSB = 4;

  logic word_ok;

  always_comb begin
    op      = alias_op_e'(bus_addr[3:2]);
    word_ok = (bus_addr[1:0] == 2'b00) && (op != OP_NONE);
    ctrl_hit = bus_en && word_ok &&
               (bus_addr[ADDR_W-1:BLK_LSB] == CTRL_BASE[ADDR_W-1:BLK_LSB]);
    irq_hit  = bus_en && word_ok &&
               (bus_addr[ADDR_W-1:BLK_LSB] == IRQ_BASE[ADDR_W-1:BLK_LSB]);
    ctrl_wr  = ctrl_hit && bus_we;
    irq_wr   = irq_hit && bus_we;
  end

endmodule

// File: rtl/irqs_src_cell.sv
module irqs_src_cell
  import irqs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      wr,
  input  alias_op_e op,
  input  logic      w_sts,
  input  logic      w_en,
  input  logic      evt,
  output logic      sts_q,
  output logic      en_q
);

  logic sts_d;
  logic en_d;
  logic upd;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    if (hold) begin
      sts_d = 1'b0;
      en_d  = 1'b0;
    end else begin
      if (wr) begin
        sts_d = apply_op(op, sts_q, w_sts);
        en_d  = apply_op(op, en_q, w_en);
      end
      // hardware event has priority over any software change
      sts_d = sts_d | evt;
    end
    upd = hold | wr | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (upd) begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !hold) |=> sts_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !hold && !(wr && op == OP_CLEAR && w_sts)
           && !(wr && op == OP_WRITE && !w_sts)) |=> sts_q); // R2

  AST_SET_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && op == OP_SET && !hold && en_q) |=> en_q); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sts_q && !en_q)); // R9

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irqs_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       NUM_SRC   = 8,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h00,
  parameter logic [ADDR_W-1:0] IRQ_BASE  = 8'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               soft_rst_o
);

  localparam int unsigned EN_LSB = NUM_SRC;
  localparam int unsigned EN_MSB = EN_LSB + NUM_SRC - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  alias_op_e op;
  logic      ctrl_hit;
  logic      irq_hit;
  logic      ctrl_wr;
  logic      irq_wr;

  irqs_decode #(
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .IRQ_BASE  (IRQ_BASE)
  ) u_decode (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .op       (op),
    .ctrl_hit (ctrl_hit),
    .irq_hit  (irq_hit),
    .ctrl_wr  (ctrl_wr),
    .irq_wr   (irq_wr)
  );

  // soft-reset bit: next value also gates the source cells at the same edge
  logic srst_q;
  logic srst_d;

  always_comb begin
    srst_d = srst_q;
    if (ctrl_wr) begin
      srst_d = apply_op(op, srst_q, bus_wdata[SRST_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      srst_q <= 1'b0;
    end else if (ctrl_wr) begin
      srst_q <= srst_d;
    end
  end

  logic [NUM_SRC-1:0] sts_q;
  logic [NUM_SRC-1:0] en_q;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    irqs_src_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .hold  (srst_d),
      .wr    (irq_wr),
      .op    (op),
      .w_sts (bus_wdata[gi]),
      .w_en  (bus_wdata[EN_LSB + gi]),
      .evt   (evt_i[gi]),
      .sts_q (sts_q[gi]),
      .en_q  (en_q[gi])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_we) begin
      if (ctrl_hit) begin
        bus_rdata[SRST_BIT] = srst_q;
      end else if (irq_hit) begin
        bus_rdata[NUM_SRC-1:0]   = sts_q;
        bus_rdata[EN_MSB:EN_LSB] = en_q;
      end
    end
  end

  assign irq_o      = |(sts_q & en_q);
  assign soft_rst_o = srst_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[SRST_BIT-1:EN_MSB+1];

  AST_SRST_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srst_q |-> !irq_o); // R9

  AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_wr && op == OP_CLEAR && !srst_d && evt_i == '0)
      |=> ((sts_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R3

  AST_SET_NO_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_wr && op == OP_SET && !srst_d)
      |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R4

endmodule

// File: tb/irq_status_regs_test.sv
module irq_status_regs_test;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_IRQ  = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_i;
  logic        irq_o;
  logic        soft_rst_o;

  always #10 clk = ~clk;

  irq_status_regs uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_i      (evt_i),
    .irq_o      (irq_o),
    .soft_rst_o (soft_rst_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    logic        sr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference state, kept from the requirements
  logic [7:0] m_sts = '0;
  logic [7:0] m_en  = '0;
  logic       m_sr  = 1'b0;

  function automatic logic [7:0] ap8(logic [1:0] o, logic [7:0] c, logic [7:0] w);
    case (o)
      2'd0: return w;
      2'd1: return c | w;
      2'd2: return c & ~w;
      default: return c;
    endcase
  endfunction

  function automatic bit valid_off(logic [7:0] a);
    return (a[1:0] == 2'b00) && (a[3:2] != 2'b11);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (!valid_off(a)) return 32'h0;
    if (a[7:4] == A_CTRL[7:4]) return {m_sr, 31'h0};
    if (a[7:4] == A_IRQ[7:4])  return {16'h0, m_en, m_sts};
    return 32'h0;
  endfunction

  task automatic drive(input bit en, input bit we, input logic [7:0] a,
                       input logic [31:0] d, input logic [7:0] ev, input string tag);
    exp_t e;
    logic sr_n;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev;
    if (en && !we) begin
      e.rd  = exp_read(a);
      e.irq = |(m_sts & m_en);
      e.sr  = m_sr;
      e.tag = tag;
      q.push_back(e);
    end
    sr_n = m_sr;
    if (en && we && valid_off(a) && a[7:4] == A_CTRL[7:4]) begin
      sr_n = ap8(a[3:2], {7'h0, m_sr}, {7'h0, d[31]})[0];
    end
    m_sr = sr_n;
    if (sr_n) begin
      m_sts = '0;
      m_en  = '0;
    end else begin
      if (en && we && valid_off(a) && a[7:4] == A_IRQ[7:4]) begin
        m_sts = ap8(a[3:2], m_sts, d[7:0]);
        m_en  = ap8(a[3:2], m_en, d[15:8]);
      end
      m_sts = m_sts | ev;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev = 8'h0);
    drive(1'b1, 1'b1, a, d, ev, "");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    drive(1'b1, 1'b0, a, 32'h0, 8'h0, tag);
  endtask

  task automatic pulse(input logic [7:0] ev);
    drive(1'b0, 1'b0, 8'h0, 32'h0, ev, "");
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h0, 32'h0, 8'h0, "");
  endtask

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && bus_en === 1'b1 && bus_we === 1'b0) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (bus_rdata !== e.rd || irq_o !== e.irq || soft_rst_o !== e.sr) begin
          n_bad++;
          $display("FAIL %s addr %h: actual rd=%h irq=%b srst=%b expected rd=%h irq=%b srst=%b",
                   e.tag, bus_addr, bus_rdata, irq_o, soft_rst_o, e.rd, e.irq, e.sr);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();

    // R1 reset state, R8 aliases read the same
    rd(A_CTRL, "R1 ctrl");
    rd(A_IRQ, "R1 irq");
    rd(A_IRQ + 8'h4, "R8 set alias");
    rd(A_IRQ + 8'h8, "R8 clr alias");

    // R2 sticky event, no irq without enable
    pulse(8'h20);
    idle();
    rd(A_IRQ, "R2 event latched");
    rd(A_IRQ, "R2 still set");

    // R4 / R6 enable via set alias
    wr(A_IRQ + 8'h4, 32'h0000_2000);
    rd(A_IRQ, "R4 R6 enable set");
    rd(A_IRQ + 8'h4, "R8 set alias read");

    pulse(8'h81);
    rd(A_IRQ, "R2 more events");

    // R3 / R11 acknowledge via clear alias
    wr(A_IRQ + 8'h8, 32'h0000_0081);
    rd(A_IRQ + 8'h8, "R3 R8 partial clear");
    wr(A_IRQ + 8'h8, 32'h0000_0020);
    rd(A_IRQ, "R11 ack keeps enable");

    // R7 event wins against clear and overwrite
    pulse(8'h04);
    wr(A_IRQ + 8'h8, 32'h0000_0004, 8'h04);
    rd(A_IRQ, "R7 set wins clear");
    wr(A_IRQ + 8'h8, 32'h0000_0008, 8'h08);
    rd(A_IRQ, "R7 set wins on zero bit");
    wr(A_IRQ, 32'h0000_2000, 8'h40);
    rd(A_IRQ, "R7 set wins overwrite");

    // R5 base write, R10 reserved bits
    wr(A_IRQ, 32'hFFFF_FF5A);
    rd(A_IRQ, "R5 R10 base write");

    // R10 unmapped offsets and addresses
    wr(A_IRQ + 8'hC, 32'hFFFF_FFFF);
    wr(A_IRQ + 8'h1, 32'h0000_0000);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(A_CTRL + 8'h2, 32'hFFFF_FFFF);
    rd(A_IRQ, "R10 unmapped writes");
    rd(A_IRQ + 8'hC, "R10 unmapped read");
    rd(8'h20, "R10 outside read");
    rd(A_CTRL, "R10 ctrl unchanged");
    wr(A_CTRL + 8'h4, 32'h7FFF_FFFF);
    rd(A_CTRL, "R10 ctrl reserved bits");

    // R6 per-bit enable position
    for (int i = 0; i < 8; i++) begin
      wr(A_IRQ, {16'h0, 8'(1 << i), 8'(1 << i)});
      rd(A_IRQ, "R6 own enable");
      wr(A_IRQ, {16'h0, 8'(1 << i), ~8'(1 << i)});
      rd(A_IRQ, "R6 other flags");
    end

    // R9 soft reset
    wr(A_IRQ, 32'h0000_FFFF);
    wr(A_CTRL + 8'h4, 32'h8000_0000);
    rd(A_CTRL, "R9 srst set");
    rd(A_IRQ, "R9 cleared at once");
    wr(A_IRQ, 32'h0000_FFFF, 8'hFF);
    pulse(8'hFF);
    rd(A_IRQ + 8'h4, "R9 held zero");
    wr(A_CTRL + 8'h8, 32'h8000_0000);
    rd(A_CTRL, "R9 released");
    rd(A_IRQ, "R9 stays default");
    wr(A_IRQ + 8'h4, 32'h0000_0100, 8'h01);
    rd(A_IRQ, "R9 works after release");
    wr(A_CTRL, 32'h8000_0000);
    rd(A_IRQ, "R9 base write srst");
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL + 8'h8, "R9 R8 base clear srst");

    repeat (3) idle();
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending reads: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule